// File: doc/BRIEF.md
# Interrupt Request Flag Register

This block collects interrupt requests from six individually sensed interrupt pins and from sixteen port pins arranged as two groups of eight, and presents them to a CPU as one 8-bit status register. All pins are active-low. Each pin first passes through a two-stage synchronizer. Each of the six interrupt pins has its own sense select. In level mode its flag tracks the pin. In falling-edge mode its flag latches and stays set until software clears it.

Software reads the register to find out which sources are requesting. An edge-latched flag can be cleared only in two steps. A read must first return 1 in that bit position, and a later write of 0 to the same bit then clears it. This stops a blind write from discarding a request that software has not yet seen. The two group bits are read-only summaries. Each one is the OR of its eight port pins. A single active-high interrupt output is raised whenever any of the eight bits is set. A standby input freezes the register contents.

Top module: `irq_flag_reg`

## Requirements
- R1: After either the power-on reset `rst` or the manual reset `mrst` is asserted, the register reads 0x00 and `irq_out` is 0.
- R2: Bit mapping is as follows. Bit 7 is the group flag for port pins 0–7. Bit 6 is the group flag for port pins 8–15. Bit k (k = 0..5) is the flag for interrupt pin k. A pin change becomes visible in the register on the third rising clock edge after it is applied.
- R3: Bits 7 and 6 read 1 exactly when at least one port pin in their group is driven low. Writes do not affect them.
- R4: Writing 1 to any of bits 5..0 never sets or changes that flag.
- R5: A write of 0 to bit k clears an edge-latched flag only if a read returned 1 in bit k since the last write. A read that returned 0 in bit k does not enable a clear, even if the flag sets afterwards.
- R6: With `irq_mode[k]` = 1 (falling-edge mode), a high-to-low transition on `irq_n[k]` sets flag k. The flag stays set after the pin returns high, until a valid clear.
- R7: With `irq_mode[k]` = 0 (level mode), flag k equals the inverted synchronized pin level. A write of 0 to the flag has no lasting effect on it.
- R8: Every write, whatever its data, withdraws all pending read-as-1 clear permissions.
- R9: If a new falling edge on an edge-mode pin is registered in the same cycle as a valid clear of its flag, the flag remains set.
- R10: While `stby` is 1, the register contents do not change. Pin activity, reads and writes have no effect during that time.
- R11: `irq_out` is 1 exactly when at least one of the eight register bits is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| mrst | input | 1 | Synchronous manual reset, active high |
| stby | input | 1 | Standby: holds the register contents |
| irq_n | input | 6 | Active-low interrupt pins |
| irq_mode | input | 6 | Per-pin sense select: 0 level, 1 falling edge |
| port_n | input | 16 | Active-low port interrupt pins, two groups of eight |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register contents, combinational |
| irq_out | output | 1 | OR of all register bits |

## Verification
The two functions that can coincide are the capture of a fresh falling edge and a software clear of the same flag. Both are armed beforehand with a read that returns 1. The bench makes them meet by lowering the pin, waiting the two synchronizer edges, and then presenting the clearing write in the cycle in which the edge reaches the flag register. The result is judged correct if the flag still reads 1 afterwards. The permission must also be used up: a second bare write of 0 leaves the flag set, and only a fresh read followed by a write clears it.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  typedef enum logic {
    SENSE_LEVEL = 1'b0,
    SENSE_FALL  = 1'b1
  } sense_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  // Pins idle high (no request), so reset to ones to avoid a false edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '1;
      q  <= '1;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/irq_pin_flag.sv
module irq_pin_flag
  import irq_flag_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   hold,
  input  logic   pin_s,
  input  sense_e mode,
  input  logic   clr_req,
  input  logic   wr_any,
  input  logic   rd_any,
  output logic   flag,
  output logic   arm
);
  logic prev;
  logic fall;
  logic clr;
  logic flag_nx;
  logic arm_nx;

  assign fall = prev & ~pin_s;
  assign clr  = clr_req & arm;

  always_comb begin
    if (mode == SENSE_FALL) flag_nx = fall | (flag & ~clr);
    else                    flag_nx = ~pin_s;
  end

  always_comb begin
    if (wr_any)              arm_nx = 1'b0;
    else if (rd_any && flag) arm_nx = 1'b1;
    else                     arm_nx = arm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b1;
      flag <= 1'b0;
      arm  <= 1'b0;
    end else if (!hold) begin
      prev <= pin_s;
      flag <= flag_nx;
      arm  <= arm_nx;
    end
  end
endmodule

// File: rtl/irq_group_flag.sv
module irq_group_flag #(
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [GRP_W-1:0] pins_s,
  output logic             flag
);
  always_ff @(posedge clk) begin
    if (rst)        flag <= 1'b0;
    else if (!hold) flag <= |(~pins_s);
  end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irq_flag_pkg::*;
#(
  parameter int N_IRQ = 6,
  parameter int N_GRP = 2,
  parameter int GRP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mrst,
  input  logic                     stby,
  input  logic [N_IRQ-1:0]         irq_n,
  input  logic [N_IRQ-1:0]         irq_mode,
  input  logic [N_GRP*GRP_W-1:0]   port_n,
  input  logic                     rd_en,
  input  logic                     wr_en,
  input  logic [N_IRQ+N_GRP-1:0]   wr_data,
  output logic [N_IRQ+N_GRP-1:0]   rd_data,
  output logic                     irq_out
);
  localparam int REG_W  = N_IRQ + N_GRP;
  localparam int N_PORT = N_GRP * GRP_W;

  logic              rst_all;
  logic              wr_ok;
  logic              rd_ok;
  logic [N_IRQ-1:0]  irq_s;
  logic [N_PORT-1:0] port_s;
  logic [N_IRQ-1:0]  irq_flag;
  logic [N_IRQ-1:0]  arm_q;
  logic [N_GRP-1:0]  grp_flag;
  logic [REG_W-1:0]  flags;

  assign rst_all = rst | mrst;
  assign wr_ok   = wr_en & ~stby;
  assign rd_ok   = rd_en & ~stby;

  irq_sync #(.W(N_IRQ)) u_sync_irq (
    .clk (clk), .rst (rst_all), .d (irq_n), .q (irq_s)
  );

  irq_sync #(.W(N_PORT)) u_sync_port (
    .clk (clk), .rst (rst_all), .d (port_n), .q (port_s)
  );

  for (genvar i = 0; i < N_IRQ; i++) begin : g_pin
    irq_pin_flag u_pin (
      .clk     (clk),
      .rst     (rst_all),
      .hold    (stby),
      .pin_s   (irq_s[i]),
      .mode    (sense_e'(irq_mode[i])),
      .clr_req (wr_ok & ~wr_data[i]),
      .wr_any  (wr_ok),
      .rd_any  (rd_ok),
      .flag    (irq_flag[i]),
      .arm     (arm_q[i])
    );
    assign flags[i] = irq_flag[i];
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    irq_group_flag #(.GRP_W(GRP_W)) u_grp (
      .clk    (clk),
      .rst    (rst_all),
      .hold   (stby),
      .pins_s (port_s[g*GRP_W +: GRP_W]),
      .flag   (grp_flag[g])
    );
    assign flags[REG_W-1-g] = grp_flag[g];
  end

  assign rd_data = flags;
  assign irq_out = |flags;
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk #(
  parameter int N_IRQ = 6,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             mrst,
  input logic             stby,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [N_IRQ-1:0] irq_mode,
  input logic [REG_W-1:0] rd_data,
  input logic             irq_out,
  input logic [N_IRQ-1:0] arm
);
  AST_IRQ_OUT_OR: assert property (@(posedge clk) disable iff (rst || mrst)
    irq_out == (rd_data != '0)); // R11

  AST_STBY_FROZEN: assert property (@(posedge clk) disable iff (rst || mrst)
    stby |=> $stable(rd_data)); // R10

  AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (rst || mrst)
    ($past(wr_en && !stby) && !$past(rst || mrst)) |-> (arm == '0)); // R8

  for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst || mrst)
      ($fell(rd_data[i]) && $past(irq_mode[i]) && !$past(rst || mrst))
        |-> ($past(wr_en) && !$past(wr_data[i]) && $past(arm[i]))); // R5

    AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (rst || mrst)
      ($past(irq_mode[i]) && $past(rd_data[i]) && !$past(wr_en) && !$past(rst || mrst))
        |-> rd_data[i]); // R6
  end
endmodule

bind irq_flag_reg irq_flag_chk #(.N_IRQ(N_IRQ), .REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mrst     (mrst),
  .stby     (stby),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .irq_mode (irq_mode),
  .rd_data  (rd_data),
  .irq_out  (irq_out),
  .arm      (arm_q)
);

// File: tb/irq_flag_reg_test.sv
module irq_flag_reg_test;
  logic        clk = 1'b0;
  logic        rst, mrst, stby, rd_en, wr_en;
  logic [5:0]  irq_n, irq_mode;
  logic [15:0] port_n;
  logic [7:0]  wr_data, rd_data;
  logic        irq_out;
  int          checks = 0;
  int          errors = 0;
  logic [7:0]  rv;

  always #5 clk = ~clk;

  irq_flag_reg uut (
    .clk(clk), .rst(rst), .mrst(mrst), .stby(stby), .irq_n(irq_n),
    .irq_mode(irq_mode), .port_n(port_n), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(output logic [7:0] v);
    rd_en = 1'b1;
    #1 v = rd_data;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int k);
    irq_n[k] = 1'b0;
    tick(3);
    irq_n[k] = 1'b1;
    tick(3);
  endtask

  task automatic t_reset;
    check("R1 power-on reset", rd_data, 8'h00);
    check("R1 irq_out after reset", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_latency;
    irq_n[3] = 1'b0;
    tick(2);
    check("R2 not yet visible after two edges", rd_data, 8'h00);
    tick(1);
    check("R2 irq3 on bit 3 after third edge", rd_data, 8'h08);
    check("R11 irq_out set", {7'b0, irq_out}, 8'h01);
    irq_n[3] = 1'b1;
    tick(3);
    check("R11 irq_out clear", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_group;
    port_n[2] = 1'b0;
    tick(3);
    check("R3 low group on bit 7", rd_data, 8'h80);
    port_n[12] = 1'b0;
    tick(3);
    check("R3 high group on bit 6", rd_data, 8'hC0);
    rd(rv);
    wr(8'h00);
    check("R3 write ignored by group bits", rd_data, 8'hC0);
    port_n = '1;
    tick(3);
    check("R3 groups drop with pins", rd_data, 8'h00);
  endtask

  task automatic t_level;
    irq_n[1] = 1'b0;
    tick(3);
    check("R7 level flag follows pin", rd_data, 8'h02);
    rd(rv);
    wr(8'h00);
    tick(1);
    check("R7 write 0 has no lasting effect", rd_data, 8'h02);
    irq_n[1] = 1'b1;
    tick(3);
    check("R7 level flag drops with pin", rd_data, 8'h00);
  endtask

  task automatic t_edge;
    irq_mode[0] = 1'b1;
    pulse(0);
    check("R6 edge flag held after pin release", rd_data, 8'h01);
    wr(8'hFF);
    check("R4 writing ones changes nothing", rd_data, 8'h01);
    wr(8'h00);
    check("R5 write 0 without read keeps flag", rd_data, 8'h01);
    rd(rv);
    check("R5 read returns flag", rv, 8'h01);
    wr(8'h00);
    check("R5 read then write 0 clears", rd_data, 8'h00);
  endtask

  task automatic t_arm_rules;
    irq_mode[2] = 1'b1;
    rd(rv);
    pulse(2);
    wr(8'h00);
    check("R5 read of 0 does not arm", rd_data, 8'h04);
    rd(rv);
    wr(8'hFF);
    wr(8'h00);
    check("R8 any write disarms", rd_data, 8'h04);
    rd(rv);
    wr(8'h00);
    check("R8 rearmed clear works", rd_data, 8'h00);
  endtask

  task automatic t_collide;
    pulse(0);
    rd(rv);
    irq_n[0] = 1'b0;
    tick(2);
    wr(8'h00);
    check("R9 edge and clear same cycle keep flag", rd_data, 8'h01);
    irq_n[0] = 1'b1;
    tick(3);
    wr(8'h00);
    check("R9 clear permission consumed", rd_data, 8'h01);
    rd(rv);
    wr(8'h00);
    check("R9 later clear works", rd_data, 8'h00);
  endtask

  task automatic t_standby;
    pulse(0);
    stby = 1'b1;
    irq_n[5] = 1'b0;
    port_n[0] = 1'b0;
    rd(rv);
    wr(8'h00);
    tick(4);
    check("R10 standby holds contents", rd_data, 8'h01);
    stby = 1'b0;
    tick(3);
    check("R10 update resumes after standby", rd_data, 8'hA1);
    irq_n[5] = 1'b1;
    port_n[0] = 1'b1;
    tick(3);
    check("R10 level sources released", rd_data, 8'h01);
  endtask

  task automatic t_manual_reset;
    mrst = 1'b1;
    tick(1);
    mrst = 1'b0;
    check("R1 manual reset clears", rd_data, 8'h00);
    check("R1 irq_out after manual reset", {7'b0, irq_out}, 8'h00);
  endtask

  initial begin
    rst = 1'b1; mrst = 1'b0; stby = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    wr_data = '0; irq_n = '1; irq_mode = '0; port_n = '1;
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_latency();
    t_group();
    t_level();
    t_edge();
    t_arm_rules();
    t_collide();
    t_standby();
    t_manual_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule